// File: doc/BRIEF.md
# Multichannel Signal Detect and Squelch Controller

This block sits beside a twelve-lane parallel receiver and decides, lane by lane, whether the incoming signal is strong enough to trust. Each lane presents an unsigned level code. The block compares it with two programmable thresholds, a higher one to declare a lane good and a lower one to declare it lost. A per-lane detect flag with hysteresis results. A flag only changes after the new condition has held for a programmable number of consecutive cycles, so short glitches are filtered out.

The flags are ANDed into one aggregate detect output, which drops as soon as any single lane is lost. A detect-enable input overrides this: when it is low, the aggregate reads high and every lane is treated as good. The block also produces three mutually exclusive controls per lane for the downstream data path: squelch, force-high and pass (data valid). Receiver-enable low forces every lane high. Otherwise, with squelch enabled, a lane without detect is muted. In every other case the lane passes.

The two thresholds come from configuration registers. The block flags an inverted pair, where the assert threshold is below the deassert threshold. While the pair is inverted, detection is frozen.

Top module: `sigdet_squelch_ctrl`

## Requirements
- R1: After synchronous reset every lane flag is 0 and every dwell count is cleared. With all enables high, `sig_det` is 0, `squelch` is all ones, `data_valid` is 0 and `force_hi` is 0.
- R2: A lane flag at 0 becomes 1 on the D-th rising edge of a run of consecutive edges at which the lane's level is greater than or equal to `thr_assert`. D is `dwell_cycles`, and a value of 0 is treated as 1. A level of `thr_assert` minus one never sets the flag.
- R3: A lane flag at 1 becomes 0 on the D-th consecutive edge at which the level is strictly below `thr_deassert`. Levels from `thr_deassert` upward leave a set flag at 1, and this includes the band between the two thresholds.
- R4: If the qualifying condition is interrupted before D consecutive edges, the flag does not change. The count restarts from zero.
- R5: With `sd_en` high, `sig_det` is the AND of all twelve lane flags. It is 0 when any one lane flag is 0.
- R6: With `sd_en` low, `sig_det` is 1 and every lane is treated as detected for gating, so no lane is squelched.
- R7: With `rx_en` and `sq_en` high, a lane whose effective detect is 0 has `squelch`=1 and `data_valid`=0. A lane whose effective detect is 1 has `data_valid`=1. Bit i of each output vector belongs to lane i.
- R8: With `rx_en` high and `sq_en` low, every lane has `data_valid`=1 and `squelch`=0, whatever its flag.
- R9: With `rx_en` low, every lane has `force_hi`=1, `data_valid`=0 and `squelch`=0, whatever the other inputs. In every case exactly one of the three controls is set per lane.
- R10: `cfg_bad` is 1 exactly when `thr_assert` < `thr_deassert`. While it is 1, lane flags hold their value and dwell counts clear. Once the pair is valid again, a full run of D edges is needed to change a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver output enable; low forces all lanes high |
| sq_en | input | 1 | Squelch enable |
| sd_en | input | 1 | Detect enable; low overrides detect to good |
| thr_assert | input | LVL_W | Level at or above which a lane becomes good |
| thr_deassert | input | LVL_W | Level below which a good lane is lost |
| dwell_cycles | input | CNT_W | Consecutive edges required before a flag changes (0 acts as 1) |
| lvl_bus | input | NCH*LVL_W | Packed lane level codes, lane i at bits i*LVL_W upward |
| sig_det | output | 1 | Aggregate detect |
| ch_det | output | NCH | Per-lane detect flags |
| cfg_bad | output | 1 | Threshold pair is inverted |
| squelch | output | NCH | Per-lane mute |
| force_hi | output | NCH | Per-lane force-high |
| data_valid | output | NCH | Per-lane pass / data valid |

## Verification
The detector is driven with all lanes rising together and with a single lane falling, and with levels parked inside the hysteresis band. Levels at exactly each threshold and one code either side of it separate `>=` from `>` and `<` from `<=`. Interrupted runs that total D edges, but are not consecutive, show whether the dwell count restarts. Different enable combinations with one lane lost show the priority between receiver-enable, detect-enable and squelch. An inverted threshold pair shows both the freeze of the flags and the count restart once the pair is valid again.

// File: rtl/sdsq_pkg.sv
package sdsq_pkg;

    typedef enum logic [1:0] {
        GM_FORCE = 2'd0,
        GM_MUTE  = 2'd1,
        GM_PASS  = 2'd2
    } gate_mode_e;

    typedef struct packed {
        logic squelch;
        logic force_hi;
        logic pass;
    } lane_ctl_t;

    // Priority: receiver disabled, then mute, then pass.
    function automatic gate_mode_e pick_mode(input logic rx_on,
                                             input logic sq_on,
                                             input logic det_good);
        if (!rx_on)
            return GM_FORCE;
        else if (sq_on && !det_good)
            return GM_MUTE;
        else
            return GM_PASS;
    endfunction

    function automatic lane_ctl_t mode_to_ctl(input gate_mode_e m);
        lane_ctl_t c;
        c = '0;
        case (m)
            GM_FORCE: c.force_hi = 1'b1;
            GM_MUTE:  c.squelch  = 1'b1;
            default:  c.pass     = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdsq_lane_det.sv
module sdsq_lane_det #(
    parameter int LVL_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] dwell,
    input  logic             hold,
    output logic             det
);
    localparam int CW1 = CNT_W + 1;

    logic             det_q;
    logic [CNT_W-1:0] cnt_q;
    logic             want;
    logic [CW1-1:0]   need;
    logic             expire;

    always_comb begin
        if (det_q)
            want = !(lvl < thr_lo);
        else
            want = (lvl >= thr_hi);
    end

    always_comb begin
        need   = (dwell == '0) ? CW1'(1) : {1'b0, dwell};
        expire = (({1'b0, cnt_q} + CW1'(1)) >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= 1'b0;
            cnt_q <= '0;
        end else if (hold || (want == det_q)) begin
            cnt_q <= '0;
        end else if (expire) begin
            det_q <= want;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign det = det_q;

    AST_RISE_AT_THRESH: assert property (@(posedge clk) disable iff (rst)
        $rose(det_q) |-> $past(lvl >= thr_hi)); // R2
    AST_FALL_BELOW_THRESH: assert property (@(posedge clk) disable iff (rst)
        $fell(det_q) |-> $past(lvl < thr_lo)); // R3
    AST_FREEZE_ON_BAD_CFG: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(det_q)); // R10

endmodule

// File: rtl/sdsq_gate.sv
module sdsq_gate
    import sdsq_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_en,
    input  logic           sq_en,
    input  logic [NCH-1:0] det_eff,
    output logic [NCH-1:0] squelch,
    output logic [NCH-1:0] force_hi,
    output logic [NCH-1:0] pass
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        lane_ctl_t ctl;
        always_comb ctl = mode_to_ctl(pick_mode(rx_en, sq_en, det_eff[i]));
        assign squelch[i]  = ctl.squelch;
        assign force_hi[i] = ctl.force_hi;
        assign pass[i]     = ctl.pass;

        AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
            $countones({squelch[i], force_hi[i], pass[i]}) == 1); // R9
        AST_RX_OFF_HIGH: assert property (@(posedge clk) disable iff (rst)
            !rx_en |-> force_hi[i] && !pass[i]); // R9
        AST_SQ_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
            (rx_en && !sq_en) |-> pass[i]); // R8
        AST_MUTE_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
            (rx_en && sq_en && !det_eff[i]) |-> squelch[i]); // R7
    end

endmodule

// File: rtl/sigdet_squelch_ctrl.sv
module sigdet_squelch_ctrl
    import sdsq_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int LVL_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_en,
    input  logic                 sq_en,
    input  logic                 sd_en,
    input  logic [LVL_W-1:0]     thr_assert,
    input  logic [LVL_W-1:0]     thr_deassert,
    input  logic [CNT_W-1:0]     dwell_cycles,
    input  logic [NCH*LVL_W-1:0] lvl_bus,
    output logic                 sig_det,
    output logic [NCH-1:0]       ch_det,
    output logic                 cfg_bad,
    output logic [NCH-1:0]       squelch,
    output logic [NCH-1:0]       force_hi,
    output logic [NCH-1:0]       data_valid
);
    logic [NCH-1:0] det_eff;

    assign cfg_bad = (thr_assert < thr_deassert);

    for (genvar i = 0; i < NCH; i++) begin : g_det
        sdsq_lane_det #(
            .LVL_W(LVL_W),
            .CNT_W(CNT_W)
        ) u_det (
            .clk   (clk),
            .rst   (rst),
            .lvl   (lvl_bus[i*LVL_W +: LVL_W]),
            .thr_hi(thr_assert),
            .thr_lo(thr_deassert),
            .dwell (dwell_cycles),
            .hold  (cfg_bad),
            .det   (ch_det[i])
        );
    end

    assign det_eff = sd_en ? ch_det : {NCH{1'b1}};
    assign sig_det = &det_eff;

    sdsq_gate #(.NCH(NCH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .sq_en   (sq_en),
        .det_eff (det_eff),
        .squelch (squelch),
        .force_hi(force_hi),
        .pass    (data_valid)
    );

    AST_AGG_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        (sd_en && sig_det) |-> (&ch_det)); // R5
    AST_AGG_DROPS_ANY: assert property (@(posedge clk) disable iff (rst)
        (sd_en && !(&ch_det)) |-> !sig_det); // R5
    AST_SD_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        !sd_en |-> (sig_det && squelch == '0)); // R6

endmodule

// File: tb/tb_sigdet_squelch_ctrl.sv
module tb_sigdet_squelch_ctrl;
    localparam int CLK_P = 10;
    localparam int NCH   = 12;
    localparam int LVL_W = 8;
    localparam int CNT_W = 8;
    localparam logic [NCH-1:0] ALL = {NCH{1'b1}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b1, sq_en = 1'b1, sd_en = 1'b1;
    logic [LVL_W-1:0] thr_a = 8'd100, thr_d = 8'd60;
    logic [CNT_W-1:0] dwell = 8'd4;
    logic [LVL_W-1:0] lv [NCH];
    logic [NCH*LVL_W-1:0] lvl_bus;
    logic sig_det, cfg_bad;
    logic [NCH-1:0] ch_det, squelch, force_hi, data_valid;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb
        for (int i = 0; i < NCH; i++) lvl_bus[i*LVL_W +: LVL_W] = lv[i];

    sigdet_squelch_ctrl #(.NCH(NCH), .LVL_W(LVL_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .sq_en(sq_en), .sd_en(sd_en),
        .thr_assert(thr_a), .thr_deassert(thr_d), .dwell_cycles(dwell),
        .lvl_bus(lvl_bus), .sig_det(sig_det), .ch_det(ch_det), .cfg_bad(cfg_bad),
        .squelch(squelch), .force_hi(force_hi), .data_valid(data_valid));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) lv[i] = 8'd0;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 ch_det", 32'(ch_det), 32'(0));
        chk("R1 sig_det", 32'(sig_det), 32'(0));
        chk("R1 squelch", 32'(squelch), 32'(ALL));
        chk("R1 valid", 32'(data_valid), 32'(0));
        chk("R1 force_hi", 32'(force_hi), 32'(0));
    endtask

    task automatic t_rise_all;
        for (int i = 0; i < NCH; i++) lv[i] = 8'd120;
        step(3);
        chk("R2 before dwell", 32'(ch_det), 32'(0));
        step(1);
        chk("R2 rise at dwell", 32'(ch_det), 32'(ALL));
        chk("R5 all good", 32'(sig_det), 32'(1));
        chk("R7 all pass", 32'(data_valid), 32'(ALL));
    endtask

    task automatic t_hysteresis;
        lv[3] = 8'd80;
        step(10);
        chk("R3 band holds", 32'(ch_det), 32'(ALL));
        lv[3] = 8'd59;
        step(3);
        chk("R3 before dwell", 32'(ch_det), 32'(ALL));
        step(1);
        chk("R3 fall", 32'(ch_det), 32'(ALL & ~(12'd1 << 3)));
        chk("R5 one lane lost", 32'(sig_det), 32'(0));
        chk("R7 mute lane3", 32'(squelch), 32'(12'd1 << 3));
        chk("R7 valid others", 32'(data_valid), 32'(ALL & ~(12'd1 << 3)));
    endtask

    task automatic t_glitch;
        lv[3] = 8'd120;
        step(2);
        lv[3] = 8'd50;
        step(1);
        lv[3] = 8'd120;
        step(3);
        chk("R4 interrupted run", 32'(ch_det[3]), 32'(0));
        step(1);
        chk("R4 full run", 32'(ch_det[3]), 32'(1));
    endtask

    task automatic t_edges;
        lv[7] = 8'd60;
        step(6);
        chk("R3 at deassert holds", 32'(ch_det[7]), 32'(1));
        lv[7] = 8'd59;
        step(4);
        chk("R3 one below falls", 32'(ch_det[7]), 32'(0));
        lv[7] = 8'd99;
        step(6);
        chk("R2 one below assert", 32'(ch_det[7]), 32'(0));
        lv[7] = 8'd100;
        step(4);
        chk("R2 exact assert rises", 32'(ch_det[7]), 32'(1));
    endtask

    task automatic t_enables;
        lv[7] = 8'd0;
        step(4);
        chk("R3 lane7 lost", 32'(ch_det), 32'(ALL & ~(12'd1 << 7)));
        sq_en = 1'b0;
        #1;
        chk("R8 no squelch", 32'(squelch), 32'(0));
        chk("R8 all valid", 32'(data_valid), 32'(ALL));
        chk("R5 still low", 32'(sig_det), 32'(0));
        sq_en = 1'b1;
        sd_en = 1'b0;
        #1;
        chk("R6 forced detect", 32'(sig_det), 32'(1));
        chk("R6 no squelch", 32'(squelch), 32'(0));
        chk("R6 all valid", 32'(data_valid), 32'(ALL));
        sd_en = 1'b1;
        #1;
        chk("R7 mute back", 32'(squelch), 32'(12'd1 << 7));
        rx_en = 1'b0;
        #1;
        chk("R9 force all", 32'(force_hi), 32'(ALL));
        chk("R9 no valid", 32'(data_valid), 32'(0));
        chk("R9 no squelch", 32'(squelch), 32'(0));
        sd_en = 1'b0;
        sq_en = 1'b0;
        #1;
        chk("R9 over other enables", 32'(force_hi), 32'(ALL));
        rx_en = 1'b1;
        sd_en = 1'b1;
        sq_en = 1'b1;
        #1;
    endtask

    task automatic t_cfg;
        thr_a = 8'd50;
        thr_d = 8'd70;
        #1;
        chk("R10 cfg_bad set", 32'(cfg_bad), 32'(1));
        lv[7] = 8'd200;
        lv[0] = 8'd0;
        step(8);
        chk("R10 frozen", 32'(ch_det), 32'(ALL & ~(12'd1 << 7)));
        thr_a = 8'd100;
        thr_d = 8'd60;
        #1;
        chk("R10 cfg_bad clear", 32'(cfg_bad), 32'(0));
        step(3);
        chk("R10 count restarted", 32'(ch_det), 32'(ALL & ~(12'd1 << 7)));
        step(1);
        chk("R10 lanes move", 32'(ch_det), 32'(ALL & ~12'd1));
    endtask

    task automatic t_dwell_zero;
        lv[0] = 8'd150;
        dwell = 8'd0;
        step(1);
        chk("R2 dwell 0 acts as 1", 32'(ch_det[0]), 32'(1));
        lv[0] = 8'd10;
        step(1);
        chk("R3 dwell 0 acts as 1", 32'(ch_det[0]), 32'(0));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_rise_all();
                t_hysteresis();
                t_glitch();
                t_edges();
                t_enables();
                t_cfg();
                t_dwell_zero();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule